// File: doc/BRIEF.md
# DDR4 Soft Row Repair Sequencer

This block drives one soft post-package repair of a failing row on a DDR4 rank. It takes a request that names the target port, master rank, slave rank, bank group, bank, row, and a bitmap that selects which devices on the rank take the repair. It then owns the DRAM command bus until the repair is done. In that time it issues a fixed, timed series of mode-register, activate, write, precharge-all and deselect commands. It also presents the data pattern for the repair write and holds refresh off.

The nominal MR0 and MR4 values and the timing values (activate-to-write delay, write recovery, CWL, additive latency and parity latency) arrive on configuration inputs and are sampled each time they are used. The mode-register settle time and the program-exit time are parameters. A request on a part that is not DDR4 is refused with a one-cycle error pulse. A one-cycle done pulse ends a repair that is accepted.

Top module: `rowfix_seq`

## Requirements
- R1: If start is high while idle and cfg_ddr4_i is low, err_o is high for exactly the next cycle. In that case busy_o stays low, no command other than deselect is issued, and refresh_en_o keeps tracking refresh_req_i.
- R2: The edge that accepts a request samples refresh_req_i. From the next cycle refresh_en_o is 0 for as long as busy_o is high. In the done cycle refresh_en_o equals the sampled value. In every other idle cycle it equals refresh_req_i from the previous cycle.
- R3: Command codes on {act_n, ras_n, cas_n, we_n} are: ACT=0111, MRS=1000, WR=1100, PRE-all=1010 with address bit 10 set, and deselect=1111. The cycle after acceptance is a deselect, and the first command follows it. The commands come in this order: PRE-all, MR4, four MR0 keys, ACT, WR, PRE-all, MR4, MR0.
- R4: Each MRS is followed by exactly TMOD-1 deselect cycles (TMOD=24 by default) before the next command or before the done cycle.
- R5: ACT carries the target row on the address. ACT and WR carry the bank field {bank[1:0], bank_group[1:0]}, that is (bank<<2)|bank_group. WR carries column 0 on the address.
- R6: The first PRE-all is followed by tRCD-1 deselects, and so is the ACT. A tRCD of 0 is treated as 1.
- R7: The WR is followed by tWR+CWL+AL+PL+10-1 deselects.
- R8: While busy_o is high, wr_pat_o equals the bitwise inverse of the device-select bitmap sampled at acceptance, so a selected device gets 0. While idle, wr_pat_o is all ones.
- R9: The second PRE-all is followed by exactly PGM_EXIT (18) deselect cycles, and then the closing MR4.
- R10: The MRS bank field is 4'h1 for MR4 and 4'h0 for MR0. The first MR4 address is the nominal MR4 with bit 5 set. The four MR0 key addresses are 0x0CFF, 0x07FF, 0x0BFF and 0x03FF, in that order. The closing MR4 and MR0 addresses are their nominal values.
- R11: Every cycle without a command, whether busy or idle, and every cycle of reset, shows deselect (1111) with address and bank 0.
- R12: done_o is high for exactly one cycle, 24 cycles after the final MR0, with busy_o already low. A start pulse while busy_o is high has no effect. A start pulse in the done cycle begins a new repair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| req_port_i | input | PORT_W | Target port |
| req_mrank_i | input | MRANK_W | Target master rank |
| req_srank_i | input | SRANK_W | Target slave rank |
| req_bg_i | input | 2 | Target bank group |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_sel_i | input | NDEV | Device-select bitmap, 1 = repair |
| cfg_ddr4_i | input | 1 | Configured generation is DDR4 |
| cfg_mr0_i | input | 16 | Nominal MR0 value |
| cfg_mr4_i | input | 16 | Nominal MR4 value |
| cfg_trcd_i | input | TW | Activate-to-write delay, clocks |
| cfg_twr_i | input | TW | Write recovery, clocks |
| cfg_cwl_i | input | TW | CAS write latency |
| cfg_al_i | input | TW | Additive latency |
| cfg_pl_i | input | TW | Parity latency |
| refresh_req_i | input | 1 | Refresh enable requested by the owner |
| refresh_en_o | output | 1 | Refresh enable sent to the refresh engine |
| cmd_act_n_o | output | 1 | ACT_n command pin |
| cmd_ras_n_o | output | 1 | RAS_n command pin |
| cmd_cas_n_o | output | 1 | CAS_n command pin |
| cmd_we_n_o | output | 1 | WE_n command pin |
| cmd_addr_o | output | ROW_W | Address pins |
| cmd_ba_o | output | 4 | {bank, bank group} pins |
| cmd_port_o | output | PORT_W | Port of the current request |
| cmd_mrank_o | output | MRANK_W | Master rank of the current request |
| cmd_srank_o | output | SRANK_W | Slave rank of the current request |
| wr_pat_o | output | NDEV | Write-data device pattern |
| busy_o | output | 1 | Sequencer owns the command bus |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse |

## Verification
Every output comes from a register. A command therefore shows up in the cycle after the edge that fires it. The first PRE-all comes two cycles after the accepting edge, and err_o one cycle after the refused start. done_o comes TMOD cycles after the final MR0, and each later command lands exactly its gap after the one before it. When a request is accepted, the bench builds a per-cycle queue of expected pin, address, bank, busy, done, error and refresh values. It pops one entry per clock edge and compares it at the falling edge. Because of this, a command one cycle early or late fails the comparison at that exact cycle.

// File: rtl/rowfix_pkg.sv
package rowfix_pkg;
  typedef struct packed {
    logic act_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_pins_t;

  localparam ctl_pins_t PINS_DES  = '{act_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ctl_pins_t PINS_ACT  = '{act_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ctl_pins_t PINS_MRS  = '{act_n: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam ctl_pins_t PINS_WR   = '{act_n: 1'b1, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
  localparam ctl_pins_t PINS_PREA = '{act_n: 1'b1, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

  localparam int unsigned STEP_W    = 4;
  localparam int unsigned NUM_STEPS = 11;
  localparam logic [3:0]  BA_MR0    = 4'h0;
  localparam logic [3:0]  BA_MR4    = 4'h1;
  localparam logic [15:0] MR4_REPAIR_BIT = 16'h0020;
endpackage

// File: rtl/rowfix_step_decode.sv
module rowfix_step_decode
  import rowfix_pkg::*;
#(
  parameter int unsigned ROW_W    = 18,
  parameter int unsigned TW       = 8,
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned TMOD     = 24,
  parameter int unsigned PGM_EXIT = 18
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [15:0]       mr0_i,
  input  logic [15:0]       mr4_i,
  input  logic [3:0]        tgt_ba_i,
  input  logic [ROW_W-1:0]  tgt_row_i,
  input  logic [TW-1:0]     trcd_i,
  input  logic [TW-1:0]     twr_i,
  input  logic [TW-1:0]     cwl_i,
  input  logic [TW-1:0]     al_i,
  input  logic [TW-1:0]     pl_i,
  output ctl_pins_t         pins_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [3:0]        ba_o,
  output logic [CNT_W-1:0]  gap_o
);
  localparam logic [CNT_W-1:0] GAP_MRS  = CNT_W'(TMOD);
  localparam logic [CNT_W-1:0] GAP_EXIT = CNT_W'(PGM_EXIT + 1);
  localparam logic [ROW_W-1:0] ADDR_ALL = ROW_W'(1) << 10;

  logic [CNT_W-1:0] trcd_gap;
  logic [CNT_W-1:0] wr_gap;

  assign trcd_gap = (trcd_i == '0) ? CNT_W'(1) : CNT_W'(trcd_i);
  assign wr_gap   = CNT_W'(twr_i) + CNT_W'(cwl_i) + CNT_W'(al_i) + CNT_W'(pl_i) + CNT_W'(10);

  always_comb begin
    pins_o = PINS_MRS;
    addr_o = '0;
    ba_o   = BA_MR0;
    gap_o  = GAP_MRS;
    case (step_i)
      4'd0: begin pins_o = PINS_PREA; addr_o = ADDR_ALL; gap_o = trcd_gap; end
      4'd1: begin addr_o = ROW_W'(mr4_i | MR4_REPAIR_BIT); ba_o = BA_MR4; end
      4'd2: addr_o = ROW_W'(16'h0CFF);
      4'd3: addr_o = ROW_W'(16'h07FF);
      4'd4: addr_o = ROW_W'(16'h0BFF);
      4'd5: addr_o = ROW_W'(16'h03FF);
      4'd6: begin pins_o = PINS_ACT; addr_o = tgt_row_i; ba_o = tgt_ba_i; gap_o = trcd_gap; end
      4'd7: begin pins_o = PINS_WR; ba_o = tgt_ba_i; gap_o = wr_gap; end
      4'd8: begin pins_o = PINS_PREA; addr_o = ADDR_ALL; gap_o = GAP_EXIT; end
      4'd9: begin addr_o = ROW_W'(mr4_i); ba_o = BA_MR4; end
      default: addr_o = ROW_W'(mr0_i);
    endcase
  end
endmodule

// File: rtl/rowfix_gap_timer.sv
module rowfix_gap_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rowfix_seq.sv
module rowfix_seq
  import rowfix_pkg::*;
#(
  parameter int unsigned NDEV     = 18,
  parameter int unsigned ROW_W    = 18,
  parameter int unsigned PORT_W   = 1,
  parameter int unsigned MRANK_W  = 3,
  parameter int unsigned SRANK_W  = 3,
  parameter int unsigned TW       = 8,
  parameter int unsigned TMOD     = 24,
  parameter int unsigned PGM_EXIT = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PORT_W-1:0]  req_port_i,
  input  logic [MRANK_W-1:0] req_mrank_i,
  input  logic [SRANK_W-1:0] req_srank_i,
  input  logic [1:0]         req_bg_i,
  input  logic [1:0]         req_bank_i,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic [NDEV-1:0]    req_sel_i,
  input  logic               cfg_ddr4_i,
  input  logic [15:0]        cfg_mr0_i,
  input  logic [15:0]        cfg_mr4_i,
  input  logic [TW-1:0]      cfg_trcd_i,
  input  logic [TW-1:0]      cfg_twr_i,
  input  logic [TW-1:0]      cfg_cwl_i,
  input  logic [TW-1:0]      cfg_al_i,
  input  logic [TW-1:0]      cfg_pl_i,
  input  logic               refresh_req_i,
  output logic               refresh_en_o,
  output logic               cmd_act_n_o,
  output logic               cmd_ras_n_o,
  output logic               cmd_cas_n_o,
  output logic               cmd_we_n_o,
  output logic [ROW_W-1:0]   cmd_addr_o,
  output logic [3:0]         cmd_ba_o,
  output logic [PORT_W-1:0]  cmd_port_o,
  output logic [MRANK_W-1:0] cmd_mrank_o,
  output logic [SRANK_W-1:0] cmd_srank_o,
  output logic [NDEV-1:0]    wr_pat_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned CNT_W = TW + 3;
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_chain_q;
  logic                   rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_q = rst_chain_q[SYNC_STAGES-1];

  // state
  logic               busy_q, busy_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               ref_q, ref_d;
  logic               saved_q, saved_d;
  logic [PORT_W-1:0]  port_q;
  logic [MRANK_W-1:0] mrank_q;
  logic [SRANK_W-1:0] srank_q;
  logic [3:0]         tgt_ba_q;
  logic [ROW_W-1:0]   row_q;
  logic [NDEV-1:0]    pat_q, pat_d;
  ctl_pins_t          pins_q, pins_d;
  logic [ROW_W-1:0]   addr_q, addr_d;
  logic [3:0]         ba_q, ba_d;

  // control terms
  logic             accept, reject, fire, last_step, issue, finish;
  logic             tmr_expired, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  ctl_pins_t        dec_pins;
  logic [ROW_W-1:0] dec_addr;
  logic [3:0]       dec_ba;
  logic [CNT_W-1:0] dec_gap;

  rowfix_step_decode #(
    .ROW_W(ROW_W), .TW(TW), .CNT_W(CNT_W), .TMOD(TMOD), .PGM_EXIT(PGM_EXIT)
  ) u_decode (
    .step_i   (step_q),
    .mr0_i    (cfg_mr0_i),
    .mr4_i    (cfg_mr4_i),
    .tgt_ba_i (tgt_ba_q),
    .tgt_row_i(row_q),
    .trcd_i   (cfg_trcd_i),
    .twr_i    (cfg_twr_i),
    .cwl_i    (cfg_cwl_i),
    .al_i     (cfg_al_i),
    .pl_i     (cfg_pl_i),
    .pins_o   (dec_pins),
    .addr_o   (dec_addr),
    .ba_o     (dec_ba),
    .gap_o    (dec_gap)
  );

  rowfix_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_expired)
  );

  assign accept    = start_i && !busy_q && cfg_ddr4_i;
  assign reject    = start_i && !busy_q && !cfg_ddr4_i;
  assign fire      = busy_q && tmr_expired;
  assign last_step = (step_q == STEP_W'(NUM_STEPS));
  assign issue     = fire && !last_step;
  assign finish    = fire && last_step;
  assign tmr_load  = accept || issue;
  assign tmr_val   = accept ? '0 : (dec_gap - CNT_W'(1));

  always_comb begin
    busy_d  = busy_q;
    step_d  = step_q;
    ref_d   = ref_q;
    saved_d = saved_q;
    pat_d   = pat_q;
    done_d  = finish;
    err_d   = reject;
    if (accept) begin
      busy_d  = 1'b1;
      step_d  = '0;
      ref_d   = 1'b0;
      saved_d = refresh_req_i;
      pat_d   = ~req_sel_i;
    end else if (finish) begin
      busy_d  = 1'b0;
      ref_d   = saved_q;
      pat_d   = '1;
    end else if (!busy_q) begin
      ref_d   = refresh_req_i;
    end
    if (issue) step_d = step_q + STEP_W'(1);
    pins_d = issue ? dec_pins : PINS_DES;
    addr_d = issue ? dec_addr : '0;
    ba_d   = issue ? dec_ba   : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ref_q   <= 1'b0;
      saved_q <= 1'b0;
      pat_q   <= '1;
      pins_q  <= PINS_DES;
      addr_q  <= '0;
      ba_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ref_q   <= ref_d;
      saved_q <= saved_d;
      pat_q   <= pat_d;
      pins_q  <= pins_d;
      addr_q  <= addr_d;
      ba_q    <= ba_d;
    end
  end

  // request fields, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      port_q   <= '0;
      mrank_q  <= '0;
      srank_q  <= '0;
      tgt_ba_q <= '0;
      row_q    <= '0;
    end else if (accept) begin
      port_q   <= req_port_i;
      mrank_q  <= req_mrank_i;
      srank_q  <= req_srank_i;
      tgt_ba_q <= {req_bank_i, req_bg_i};
      row_q    <= req_row_i;
    end
  end

  assign refresh_en_o = ref_q;
  assign cmd_act_n_o  = pins_q.act_n;
  assign cmd_ras_n_o  = pins_q.ras_n;
  assign cmd_cas_n_o  = pins_q.cas_n;
  assign cmd_we_n_o   = pins_q.we_n;
  assign cmd_addr_o   = addr_q;
  assign cmd_ba_o     = ba_q;
  assign cmd_port_o   = port_q;
  assign cmd_mrank_o  = mrank_q;
  assign cmd_srank_o  = srank_q;
  assign wr_pat_o     = pat_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/rowfix_seq_chk.sv
module rowfix_seq_chk #(
  parameter int unsigned TMOD = 24
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic refresh_en,
  input logic act_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  logic       is_des, is_mrs, mrs_seen;
  logic [7:0] since_mrs;

  assign is_des = act_n && ras_n && cas_n && we_n;
  assign is_mrs = act_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_seen  <= 1'b0;
      since_mrs <= '0;
    end else if (is_mrs) begin
      mrs_seen  <= 1'b1;
      since_mrs <= 8'd1;
    end else if (since_mrs != 8'hFF) begin
      since_mrs <= since_mrs + 8'd1;
    end
  end

  assert_mrs_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_des && mrs_seen) |-> (since_mrs >= 8'(TMOD)));

  assert_des_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> is_des);

  assert_refresh_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !refresh_en);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_err_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));
endmodule

bind rowfix_seq rowfix_seq_chk #(.TMOD(TMOD)) u_rowfix_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .busy      (busy_o),
  .done      (done_o),
  .err       (err_o),
  .refresh_en(refresh_en_o),
  .act_n     (cmd_act_n_o),
  .ras_n     (cmd_ras_n_o),
  .cas_n     (cmd_cas_n_o),
  .we_n      (cmd_we_n_o)
);

// File: tb/rowfix_seq_bench.sv
`timescale 1ns/1ps
module rowfix_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        req_port;
  logic [2:0]  req_mrank, req_srank;
  logic [1:0]  req_bg, req_bank;
  logic [17:0] req_row, req_sel;
  logic        ddr4;
  logic [15:0] mr0, mr4;
  logic [7:0]  trcd, twr, cwl, al, pl;
  logic        refresh_req;

  wire        refresh_en, act_n, ras_n, cas_n, we_n, c_port, busy, done, err;
  wire [17:0] c_addr, wr_pat;
  wire [3:0]  c_ba;
  wire [2:0]  c_mrank, c_srank;

  always #5 clk = ~clk;

  rowfix_seq u_rowfix_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .req_port_i(req_port), .req_mrank_i(req_mrank), .req_srank_i(req_srank),
    .req_bg_i(req_bg), .req_bank_i(req_bank), .req_row_i(req_row), .req_sel_i(req_sel),
    .cfg_ddr4_i(ddr4), .cfg_mr0_i(mr0), .cfg_mr4_i(mr4),
    .cfg_trcd_i(trcd), .cfg_twr_i(twr), .cfg_cwl_i(cwl), .cfg_al_i(al), .cfg_pl_i(pl),
    .refresh_req_i(refresh_req), .refresh_en_o(refresh_en),
    .cmd_act_n_o(act_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_addr_o(c_addr), .cmd_ba_o(c_ba), .cmd_port_o(c_port),
    .cmd_mrank_o(c_mrank), .cmd_srank_o(c_srank), .wr_pat_o(wr_pat),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  typedef struct {
    logic [3:0]  pins;
    logic [17:0] addr;
    logic [3:0]  ba;
    bit          busy;
    bit          done;
    bit          err;
    bit          refr;
    string       tag;
  } rec_t;

  localparam logic [3:0] P_DES = 4'b1111, P_ACT = 4'b0111, P_MRS = 4'b1000,
                         P_WR  = 4'b1100, P_PRE = 4'b1010;

  rec_t        exp_q[$];
  rec_t        cur;
  int          n_checks = 0;
  int          n_fails  = 0;
  int          n_done   = 0;
  int          wd       = 0;
  logic [17:0] m_pat;
  logic        m_port;
  logic [2:0]  m_mrank, m_srank;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic rec_t mk(logic [3:0] p, logic [17:0] a, logic [3:0] b, bit bz, string t);
    rec_t r;
    r.pins = p; r.addr = a; r.ba = b; r.busy = bz;
    r.done = 0; r.err = 0; r.refr = 0; r.tag = t;
    return r;
  endfunction

  task automatic push_cmd(logic [3:0] p, logic [17:0] a, logic [3:0] b, int gap,
                          string ctag, string dtag);
    exp_q.push_back(mk(p, a, b, 1, ctag));
    for (int i = 1; i < gap; i++) exp_q.push_back(mk(P_DES, '0, '0, 1, dtag));
  endtask

  task automatic build_seq();
    int          g_rcd;
    int          g_wr;
    logic [3:0]  tba;
    rec_t        r;
    bit          saved;
    g_rcd = (trcd == 0) ? 1 : int'(trcd);
    g_wr  = int'(twr) + int'(cwl) + int'(al) + int'(pl) + 10;
    tba   = {req_bank, req_bg};
    saved = refresh_req;
    m_pat = ~req_sel; m_port = req_port; m_mrank = req_mrank; m_srank = req_srank;
    exp_q.push_back(mk(P_DES, '0, '0, 1, "R2"));
    push_cmd(P_PRE, 18'h400, 4'h0, g_rcd, "R3", "R6");
    push_cmd(P_MRS, {2'b0, mr4 | 16'h0020}, 4'h1, 24, "R10", "R4");
    push_cmd(P_MRS, 18'h0CFF, 4'h0, 24, "R10", "R4");
    push_cmd(P_MRS, 18'h07FF, 4'h0, 24, "R10", "R4");
    push_cmd(P_MRS, 18'h0BFF, 4'h0, 24, "R10", "R4");
    push_cmd(P_MRS, 18'h03FF, 4'h0, 24, "R10", "R4");
    push_cmd(P_ACT, req_row, tba, g_rcd, "R5", "R6");
    push_cmd(P_WR, 18'h0, tba, g_wr, "R5", "R7");
    push_cmd(P_PRE, 18'h400, 4'h0, 19, "R3", "R9");
    push_cmd(P_MRS, {2'b0, mr4}, 4'h1, 24, "R10", "R4");
    push_cmd(P_MRS, {2'b0, mr0}, 4'h0, 24, "R10", "R4");
    r = mk(P_DES, '0, '0, 0, "R12");
    r.done = 1; r.refr = saved;
    exp_q.push_back(r);
  endtask

  task automatic model_edge();
    rec_t r;
    if (exp_q.size() == 0) begin
      if (start && ddr4) build_seq();
      else begin
        r = mk(P_DES, '0, '0, 0, start ? "R1" : "R11");
        r.err = start; r.refr = refresh_req;
        exp_q.push_back(r);
      end
    end
    cur = exp_q.pop_front();
  endtask

  task automatic compare();
    check(cur.tag, "pins", {28'b0, act_n, ras_n, cas_n, we_n}, {28'b0, cur.pins});
    check(cur.tag, "addr", {14'b0, c_addr}, {14'b0, cur.addr});
    check(cur.tag, "bank", {28'b0, c_ba}, {28'b0, cur.ba});
    check("R12", "busy", {31'b0, busy}, {31'b0, cur.busy});
    check("R12", "done", {31'b0, done}, {31'b0, cur.done});
    check("R1", "err", {31'b0, err}, {31'b0, cur.err});
    check("R2", "refresh", {31'b0, refresh_en}, {31'b0, cur.refr});
    if (cur.busy) begin
      check("R8", "wr_pat", {14'b0, wr_pat}, {14'b0, m_pat});
      check("R5", "target", {25'b0, c_port, c_mrank, c_srank}, {25'b0, m_port, m_mrank, m_srank});
    end else begin
      check("R8", "wr_pat idle", {14'b0, wr_pat}, {14'b0, 18'h3FFFF});
    end
    if (cur.done) n_done++;
  endtask

  task automatic cyc();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run_idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_start();
    start = 1; cyc(); start = 0;
  endtask

  task automatic wait_done();
    int d0;
    d0 = n_done;
    while (n_done == d0) cyc();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; req_port = 0; req_mrank = 0; req_srank = 0;
    req_bg = 0; req_bank = 0; req_row = 0; req_sel = 0; ddr4 = 1;
    mr0 = 16'h0A54; mr4 = 16'h1808; trcd = 3; twr = 4; cwl = 5; al = 0; pl = 0;
    refresh_req = 0;
    repeat (3) @(negedge clk);
    // reset state, R11 / R12 / R2
    check("R11", "reset pins", {28'b0, act_n, ras_n, cas_n, we_n}, {28'b0, P_DES});
    check("R12", "reset busy", {31'b0, busy}, 32'h0);
    check("R12", "reset done", {31'b0, done}, 32'h0);
    check("R2", "reset refresh", {31'b0, refresh_en}, 32'h0);
    rst_n = 1;
    run_idle(4);

    // R1: refused request on a non-DDR4 part, refresh keeps tracking
    refresh_req = 1; run_idle(2);
    ddr4 = 0; pulse_start(); run_idle(3);
    refresh_req = 0; run_idle(2); refresh_req = 1; run_idle(2);
    ddr4 = 1;

    // R3..R10: repair A, with starts ignored while busy (R12)
    req_port = 1; req_mrank = 3'd5; req_srank = 3'd2; req_bg = 2'd3; req_bank = 2'd1;
    req_row = 18'h2A5C3; req_sel = 18'h00011;
    pulse_start();
    run_idle(40);
    req_row = 18'h11111; req_bg = 2'd0;
    start = 1; run_idle(5); start = 0;
    wait_done();
    run_idle(3);

    // R6 corner: tRCD 0 treated as 1, nonzero AL/PL, refresh changes mid-run (R2)
    trcd = 0; twr = 9; cwl = 7; al = 2; pl = 3; refresh_req = 0;
    mr0 = 16'h0000; mr4 = 16'hFFDF;
    req_port = 0; req_mrank = 3'd0; req_srank = 3'd7; req_bg = 2'd1; req_bank = 2'd2;
    req_row = 18'h3FFFF; req_sel = 18'h3FFFF;
    pulse_start();
    run_idle(30); refresh_req = 1;
    wait_done();
    run_idle(3);

    // R12: start held through a done cycle starts the next repair at once
    trcd = 12; twr = 16; cwl = 11; al = 0; pl = 1;
    req_sel = 18'h20000; req_row = 18'h00001; req_bg = 2'd2; req_bank = 2'd3;
    start = 1;
    wait_done();
    req_sel = 18'h00000; req_row = 18'h12345;
    wait_done();
    start = 0;
    run_idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule